// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator

This block turns a single PWM drive bit into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a half-bridge. Whenever the drive bit changes level, the output that is switching off drops at once. The output that is switching on stays off for a programmable gap, so the two switches never conduct together and the supply is never shorted to ground through the bridge.

The gap length is chosen by a 3-bit delay code. The code is taken in only while reset is asserted and is frozen from the moment reset is released. Its eight settings map to a fixed, non-linear table of interval lengths in which a larger code gives a shorter gap. Intervals are counted in cycles of a fast timing clock. With the default table and a 0.5 ns tick, the settings span from about 62 ns down to 9 ns. Reset is synchronous and active-high.

Top module: `dt_gen`

## Requirements
- R1: While `rst` is high, `hs_en` and `ls_en` are both 0 in the cycle after each clock edge.
- R2: The delay code in force is the value of `dly_code` at the last clock edge at which `rst` was high. Changes of `dly_code` while `rst` is low have no effect on any gap.
- R3: The gap N in clock cycles follows the code: 0→124, 1→98, 2→74, 3→48, 4→30, 5→27, 6→24, 7→18. A larger code never gives a longer gap.
- R4: At the clock edge where a new level of `drive` is first sampled, the output that was on goes to 0, and both outputs are 0 after that edge.
- R5: After a change of `drive` is sampled at edge E, the output for the new level rises at edge E+N. `drive`=1 selects `hs_en` and `drive`=0 selects `ls_en`. Both outputs stay 0 at every edge in between.
- R6: The gap of R5 applies in both directions: high-side off then low-side on, and low-side off then high-side on.
- R7: If `drive` changes again before the gap has run out, the count restarts from N for the new level. Neither output rises before that new count expires.
- R8: `hs_en` and `ls_en` are never 1 in the same cycle.
- R9: After reset is released, the output selected by `drive` rises N edges after the first clock edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one cycle is one delay tick |
| rst | input | 1 | Synchronous active-high reset; the delay code is taken in while high |
| drive | input | 1 | PWM drive bit: 1 = high side on, 0 = low side on |
| dly_code | input | 3 | Delay select code, 0 = longest gap, 7 = shortest |
| hs_en | output | 1 | High-side gate enable, registered |
| ls_en | output | 1 | Low-side gate enable, registered |

## Verification
Every one of the eight codes is latched through a reset in which the code pins first hold a decoy value and then the final one. The code pins are then changed after release, which separates sampling at release from sampling during the run. Directed single edges in each direction measure the gap cycle by cycle against the table, and this exposes off-by-one counting and a swapped direction. Drive pulses shorter than the gap check that the count restarts. Random hold lengths from 1 to 160 cycles, compared each cycle against a bench model, mix complete and cut-short gaps and catch any overlap or early enable.

// File: rtl/dt_gen_pkg.sv
package dt_gen_pkg;
  localparam int DT_CODE_W = 3;
  localparam int DT_TICK_W = 8;
  localparam int DT_CODES  = 1 << DT_CODE_W;
  // Default gap table, entry for code 0 in the lowest slice
  localparam logic [DT_CODES*DT_TICK_W-1:0] DT_DEFAULT_TABLE = {
    8'd18, 8'd24, 8'd27, 8'd30, 8'd48, 8'd74, 8'd98, 8'd124
  };
endpackage

// File: rtl/dt_code_latch.sv
module dt_code_latch #(
  parameter int CODE_W = 3,
  parameter int TICK_W = 8,
  parameter logic [(1<<CODE_W)*TICK_W-1:0] TICK_TABLE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic [TICK_W-1:0] ticks
);
  logic [TICK_W-1:0] ticks_q;

  // Track the code only while reset is held; freeze on release
  always_ff @(posedge clk) begin
    if (rst) ticks_q <= TICK_TABLE[int'(code_in)*TICK_W +: TICK_W];
  end

  assign ticks = ticks_q;

  // R2
  frozen_code_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ticks_q));
endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic [TICK_W-1:0] ticks,
  output logic              hs_en,
  output logic              ls_en
);
  logic              started;
  logic              tgt;
  logic [TICK_W-1:0] cnt;
  logic              hs_q, ls_q;
  logic              new_level;

  assign new_level = !started || (drive != tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      tgt     <= 1'b0;
      cnt     <= '0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else if (new_level) begin
      started <= 1'b1;
      tgt     <= drive;
      cnt     <= ticks;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else if (cnt == TICK_W'(1)) begin
      cnt  <= '0;
      hs_q <= tgt;
      ls_q <= !tgt;
    end else if (cnt != '0) begin
      cnt <= cnt - TICK_W'(1);
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

  // R8
  no_overlap_chk: assert property (@(posedge clk) !(hs_q && ls_q));
  // R1
  reset_off_chk: assert property (@(posedge clk) rst |=> (!hs_q && !ls_q));
  // R4
  edge_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (started && drive != tgt) |=> (!hs_q && !ls_q));
  // R5
  hs_rise_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> $past(drive));
  // R5
  ls_rise_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> !$past(drive));
  // R7
  no_early_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt > TICK_W'(1)) |=> (!hs_q && !ls_q));
endmodule

// File: rtl/dt_gen.sv
module dt_gen
  import dt_gen_pkg::*;
#(
  parameter int CODE_W = DT_CODE_W,
  parameter int TICK_W = DT_TICK_W,
  parameter logic [(1<<CODE_W)*TICK_W-1:0] TICK_TABLE = DT_DEFAULT_TABLE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic [CODE_W-1:0] dly_code,
  output logic              hs_en,
  output logic              ls_en
);
  logic [TICK_W-1:0] ticks;

  dt_code_latch #(
    .CODE_W(CODE_W), .TICK_W(TICK_W), .TICK_TABLE(TICK_TABLE)
  ) u_latch (
    .clk(clk), .rst(rst), .code_in(dly_code), .ticks(ticks)
  );

  dt_gate_seq #(.TICK_W(TICK_W)) u_seq (
    .clk(clk), .rst(rst), .drive(drive), .ticks(ticks),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  // R3
  nonzero_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ticks != '0);
endmodule

// File: tb/dt_gen_bench.sv
module dt_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       drive = 1'b0;
  logic [2:0] dly_code = 3'd0;
  logic       hs_en, ls_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  dt_gen u_dt_gen (
    .clk(clk), .rst(rst), .drive(drive), .dly_code(dly_code),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int gap_of(input logic [2:0] c);
    case (c)
      3'd0: return 124;
      3'd1: return 98;
      3'd2: return 74;
      3'd3: return 48;
      3'd4: return 30;
      3'd5: return 27;
      3'd6: return 24;
      default: return 18;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural model of the requirements, stepped at each rising edge
  logic       m_hs = 1'b0, m_ls = 1'b0, m_tgt = 1'b0, m_started = 1'b0;
  int         m_cnt = 0;
  logic [2:0] m_code = 3'd0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_hs = 1'b0; m_ls = 1'b0; m_started = 1'b0; m_cnt = 0;
      m_code = dly_code;
    end else if (!m_started || drive != m_tgt) begin
      m_started = 1'b1; m_tgt = drive; m_cnt = gap_of(m_code);
      m_hs = 1'b0; m_ls = 1'b0;
    end else if (m_cnt == 1) begin
      m_cnt = 0; m_hs = m_tgt; m_ls = !m_tgt;
    end else if (m_cnt > 1) begin
      m_cnt--;
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      check("R4,R5,R7 hs_en model", int'(hs_en), int'(m_hs));
      check("R4,R5,R7 ls_en model", int'(ls_en), int'(m_ls));
      check("R8 overlap", int'(hs_en && ls_en), 0);
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count low-low samples from the first negedge after a drive change
  task automatic count_gap(output int gap);
    gap = 0;
    @(negedge clk);
    while (!hs_en && !ls_en && gap < 400) begin
      gap++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [2:0] code, input logic lvl);
    int gap;
    @(negedge clk);
    rst = 1'b1;
    dly_code = ~code;
    drive = lvl;
    wait_cycles(3);
    check("R1 reset hs_en", int'(hs_en), 0);
    check("R1 reset ls_en", int'(ls_en), 0);
    dly_code = code;
    @(negedge clk);
    rst = 1'b0;
    count_gap(gap);
    check("R9 first gap", gap, gap_of(code));
    check("R9 first output", int'(hs_en), int'(lvl));
    // R2: code pins changed while running must not matter
    dly_code = code + 3'd3;
  endtask

  task automatic edge_gap(input logic [2:0] code, input logic lvl);
    int gap;
    drive = lvl;
    count_gap(gap);
    check(lvl ? "R6 gap low->high side" : "R6 gap high->low side", gap, gap_of(code));
    check("R2,R3 gap from latched code", gap, gap_of(code));
    check("R5 hs_en after gap", int'(hs_en), int'(lvl));
    check("R5 ls_en after gap", int'(ls_en), int'(!lvl));
    wait_cycles(5);
  endtask

  task automatic short_pulse(input logic [2:0] code, input int k);
    int gap;
    logic lvl;
    lvl = !drive;
    drive = lvl;
    wait_cycles(k);
    check("R7 no early hs_en", int'(hs_en), 0);
    check("R7 no early ls_en", int'(ls_en), 0);
    drive = !lvl;
    count_gap(gap);
    check("R7 restarted gap", gap, gap_of(code));
    wait_cycles(3);
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code;
      code = 3'(c);
      do_reset(code, c[0]);
      edge_gap(code, !drive);
      edge_gap(code, !drive);
      short_pulse(code, 1);
      short_pulse(code, gap_of(code) - 1);
      dly_code = 3'($urandom_range(0, 7));
      for (int t = 0; t < 30; t++) begin
        drive = !drive;
        wait_cycles($urandom_range(1, 160));
      end
      wait_cycles(130);
      edge_gap(code, !drive);
    end
    // R3: table is non-increasing in the code
    for (int c = 0; c < 7; c++)
      check("R3 monotonic table", int'(gap_of(3'(c)) >= gap_of(3'(c + 1))), 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule